// File: doc/BRIEF.md
# Phase Current-Share Averaging Unit

This unit forms the error term for the current-balancing loop of a two-phase interleaved boost stage. A sample tick arrives at the master conversion rate, and two unsigned converter words carry the switch current of each phase. The converter samples them at mid on-time, aligned with the conversion start strobe. The unit keeps only every fourth tick. Each kept sample enters a per-phase sixteen-entry circular history, and a running sum of that history gives a smoothed average for each phase.

At a much slower rate (every 2000th tick, so 100 Hz from a 200 kHz tick), the unit subtracts the phase B average from the phase A average. It presents the signed result with a one-cycle strobe to the downstream share compensator. A flag marks the time after reset before the history holds sixteen samples. No strobe is issued while this flag is set.

Top module: `phase_share_avg`

## Requirements
- R1: A tick counter starts at zero after reset. A sample pair is captured only on the 4th, 8th, 12th, ... tick after reset. A tick that does not capture, or a cycle without a tick, leaves both averages unchanged.
- R2: Each average equals floor(sum of that phase's latest 16 captured samples / 16). Before 16 captures, the missing entries count as zero. The average changes in the cycle after the capturing tick.
- R3: The averages are 12-bit unsigned and exact at full scale. Sixteen captures of 4095 give 4095, and sixteen captures of 0 give 0.
- R4: The share error is 13-bit two's complement, equal to avg_a minus avg_b. It is taken from the averages as they stood before any capture on the same tick. It holds its value between strobes.
- R5: share_vld is a one-cycle pulse in the cycle after every 2000th tick since reset (ticks 2000, 4000, ...). It is never high at any other time.
- R6: not_ready is high from reset until the 16th capture and low from then on. No strobe is issued while not_ready was high at the strobing tick.
- R7: While reset is held low, and after it, both averages and the share error are 0, share_vld is 0 and not_ready is 1. Both decimation counters restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle sample tick at the master rate |
| adc_a | input | 12 | Phase A switch-current sample, unsigned |
| adc_b | input | 12 | Phase B switch-current sample, unsigned |
| avg_a | output | 12 | Phase A running average |
| avg_b | output | 12 | Phase B running average |
| share_err | output | 13 | Signed difference avg_a minus avg_b, held between strobes |
| share_vld | output | 1 | One-cycle strobe at the share-loop rate |
| not_ready | output | 1 | High until the history is full |

## Verification
Several properties are checked on every cycle: the averages stay constant in cycles without a tick, the strobe never lasts two cycles, the error moves only with a strobe, no strobe follows a not-ready state, and readiness never drops once reached. The bench scenarios show the rest. These are the exact capture ticks under decimation, the averages through fill and circular wrap-around, the full-scale and sign extremes of the error, the strobe landing on exactly the 2000th and 4000th tick, and the restart of all counting after a mid-run reset.

// File: rtl/phase_share_avg.sv
module phase_share_avg #(
  parameter int W         = 12,
  parameter int TAPS      = 16,
  parameter int CAP_DIV   = 4,
  parameter int SHARE_DIV = 2000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [W-1:0]        adc_a,
  input  logic [W-1:0]        adc_b,
  output logic [W-1:0]        avg_a,
  output logic [W-1:0]        avg_b,
  output logic signed [W:0]   share_err,
  output logic                share_vld,
  output logic                not_ready
);
  localparam int LT = $clog2(TAPS);
  localparam int SW = W + LT;
  localparam int CW = $clog2(CAP_DIV);
  localparam int HW = $clog2(SHARE_DIV);
  localparam int FW = $clog2(TAPS + 1);

  logic [CW-1:0] cap_cnt;
  logic [HW-1:0] sh_cnt;
  logic [LT-1:0] wp;
  logic [FW-1:0] fill;
  logic [W-1:0]  hist_a [TAPS];
  logic [W-1:0]  hist_b [TAPS];
  logic [SW-1:0] sum_a, sum_b;

  wire full = (fill == FW'(TAPS));
  wire cap  = tick && (cap_cnt == CW'(CAP_DIV - 1));
  wire shr  = tick && (sh_cnt == HW'(SHARE_DIV - 1));
  wire [W-1:0] old_a = full ? hist_a[wp] : '0;
  wire [W-1:0] old_b = full ? hist_b[wp] : '0;
  wire signed [W:0] diff = $signed({1'b0, avg_a}) - $signed({1'b0, avg_b});

  assign avg_a     = sum_a[SW-1:LT];
  assign avg_b     = sum_b[SW-1:LT];
  assign not_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_cnt <= '0;
      sh_cnt  <= '0;
    end else if (tick) begin
      cap_cnt <= (cap_cnt == CW'(CAP_DIV - 1)) ? '0 : cap_cnt + CW'(1);
      sh_cnt  <= (sh_cnt == HW'(SHARE_DIV - 1)) ? '0 : sh_cnt + HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      fill  <= '0;
      sum_a <= '0;
      sum_b <= '0;
    end else if (cap) begin
      wp    <= wp + LT'(1);
      fill  <= full ? fill : fill + FW'(1);
      sum_a <= sum_a + SW'(adc_a) - SW'(old_a);
      sum_b <= sum_b + SW'(adc_b) - SW'(old_b);
    end
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      hist_a[wp] <= adc_a;
      hist_b[wp] <= adc_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      share_vld <= 1'b0;
      share_err <= '0;
    end else begin
      share_vld <= shr && full;
      if (shr && full) share_err <= diff;
    end
  end
endmodule

// File: rtl/phase_share_avg_chk.sv
module phase_share_avg_chk #(
  parameter int W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [W-1:0]      avg_a,
  input logic [W-1:0]      avg_b,
  input logic signed [W:0] share_err,
  input logic              share_vld,
  input logic              not_ready
);
  p_avg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> ($stable(avg_a) && $stable(avg_b)));

  p_err_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !share_vld |-> $stable(share_err));

  p_pulse_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    share_vld |=> !share_vld);

  p_no_strobe_unready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    share_vld |-> !$past(not_ready));

  p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !not_ready |=> !not_ready);
endmodule

bind phase_share_avg phase_share_avg_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .avg_a(avg_a), .avg_b(avg_b),
  .share_err(share_err), .share_vld(share_vld), .not_ready(not_ready));

// File: tb/phase_share_avg_tb_top.sv
module phase_share_avg_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [11:0] adc_a = '0, adc_b = '0;
  logic [11:0] avg_a, avg_b;
  logic signed [12:0] share_err;
  logic share_vld, not_ready;

  int n_run = 0, n_fail = 0;
  int ha[16], hb[16];
  int hp, ncap, tcount;
  bit done = 0;

  localparam int NV = 6;
  localparam int VA[NV] = '{100, 4095, 0, 2048, 17, 4000};
  localparam int VB[NV] = '{300, 0, 4095, 2047, 3333, 5};

  always #10 clk = ~clk;

  phase_share_avg dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .adc_a(adc_a), .adc_b(adc_b),
    .avg_a(avg_a), .avg_b(avg_b), .share_err(share_err),
    .share_vld(share_vld), .not_ready(not_ready));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mavg(input bit ph);
    int s = 0;
    for (int i = 0; i < 16; i++) s += ph ? hb[i] : ha[i];
    return s / 16;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 16; i++) begin ha[i] = 0; hb[i] = 0; end
    hp = 0; ncap = 0; tcount = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; tick = 0;
    repeat (3) @(negedge clk);
    check(avg_a == 0 && avg_b == 0, "R7 averages in reset", avg_a + avg_b, 0);
    check(share_vld == 0 && share_err == 0, "R7 strobe/err in reset", int'(share_err), 0);
    check(not_ready == 1, "R7 not_ready in reset", not_ready, 1);
    rst_n = 1;
    model_clear();
    @(negedge clk);
  endtask

  task automatic do_tick(input int a, input int b, input int gap);
    bit is_cap, is_sh, rdy;
    int perr;
    is_cap = (tcount % 4) == 3;
    is_sh  = (tcount % 2000) == 1999;
    rdy    = ncap >= 16;
    perr   = mavg(0) - mavg(1);
    adc_a = 12'(a); adc_b = 12'(b); tick = 1;
    @(negedge clk);
    tick = 0;
    if (is_cap) begin
      ha[hp] = a; hb[hp] = b; hp = (hp + 1) % 16; ncap++;
    end
    tcount++;
    if (is_sh) begin
      check(share_vld == rdy, "R5 strobe on share tick", share_vld, rdy);
      if (rdy) check(int'(share_err) == perr, "R4 share error value", int'(share_err), perr);
    end else if (share_vld)
      check(0, "R5 unexpected strobe", 1, 0);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      if (share_vld) check(0, "R5 strobe longer than one cycle", 1, 0);
    end
  endtask

  task automatic chk_avg(input string tag);
    check(avg_a == mavg(0), {tag, " avg_a"}, avg_a, mavg(0));
    check(avg_b == mavg(1), {tag, " avg_b"}, avg_b, mavg(1));
  endtask

  initial begin
    int t0;
    t0 = 0;
    while (!done) begin
      @(posedge clk);
      t0++;
      if (t0 > 150000) begin
        n_fail++; n_run++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", t0, 150000);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    model_clear();
    do_reset();

    // R1: decimation, non-capture ticks carry different values
    do_tick(999, 999, 0); do_tick(999, 999, 1); do_tick(999, 999, 0);
    check(avg_a == 0 && avg_b == 0, "R1 no capture before 4th tick", avg_a, 0);
    do_tick(800, 160, 2);
    check(avg_a == 50, "R1 capture on 4th tick avg_a", avg_a, 50);
    check(avg_b == 10, "R1 capture on 4th tick avg_b", avg_b, 10);
    do_tick(3000, 3000, 0);
    check(avg_a == 50, "R1 non-capture tick holds avg", avg_a, 50);

    // R6: readiness after the 16th capture
    do_reset();
    for (int k = 0; k < 63; k++) do_tick(160, 320, 0);
    check(not_ready == 1, "R6 not_ready after 15 captures", not_ready, 1);
    check(avg_a == 150, "R2 partial fill avg_a", avg_a, 150);
    do_tick(160, 320, 0);
    check(not_ready == 0, "R6 ready after 16 captures", not_ready, 0);
    check(avg_a == 160 && avg_b == 320, "R2 full history", avg_a, 160);

    // Vector table: constant levels, checked halfway (wrap mix) and at end
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 32; k++) do_tick(VA[i], VB[i], i % 3);
      chk_avg("R2 mixed history");
      for (int k = 0; k < 32; k++) do_tick(VA[i], VB[i], 0);
      check(avg_a == VA[i], "R3 settled avg_a", avg_a, VA[i]);
      check(avg_b == VB[i], "R3 settled avg_b", avg_b, VB[i]);
    end

    // Share strobes: extremes then a varying pattern
    do_reset();
    for (int t = 0; t < 6000; t++) begin
      if (t < 2000) do_tick(4095, 0, 0);
      else if (t < 4000) do_tick(0, 4095, 0);
      else do_tick((t * 37) % 4096, (t * 91) % 4096, 0);
      if (t == 1999) check(int'(share_err) == 4095, "R4 max positive error", int'(share_err), 4095);
      if (t == 3999) check(int'(share_err) == -4095, "R4 max negative error", int'(share_err), -4095);
      if (t == 2500) check(int'(share_err) == 4095, "R4 error held between strobes", int'(share_err), 4095);
    end
    chk_avg("R2 varying pattern");

    // R7: mid-run reset restarts counters
    do_reset();
    do_tick(500, 500, 0); do_tick(500, 500, 0); do_tick(500, 500, 0);
    check(avg_a == 0, "R7 decimation restarted", avg_a, 0);
    do_tick(1600, 32, 0);
    check(avg_a == 100 && avg_b == 2, "R7 first capture after reset", avg_a, 100);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule